// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

The aggregator gathers six peripheral interrupt sources into a sticky pending register and combines it with a mask register to form one CPU hardware interrupt line. Each source owns a fixed pending bit: signal processor in bit 0, serial in bit 1, audio in bit 2, video in bit 3, parallel in bit 4 and display processor in bit 5. A source raises its bit with a one-cycle set pulse. The bit stays high until a per-source acknowledge pulse clears it.

Software changes the mask through a small synchronous write port. The port takes a word address, write data and per-byte enables. In the mask register, each source has a pair of fields: one that sets its mask bit and one that clears it. A separate mode register carries an acknowledge for the display-processor source.

The interrupt line is also merged into the CPU cause word. While the line is high, the cause word shows interrupt-pending bit 2 (cause bit 10) and a zero exception-code field. The block has no state machine. It is made of two register banks, a cause merge stage and an address decoder.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `pend_o`, `mask_o` and `irq_o` are all zero.
- R2: A set pulse on `src_set[i]` makes `pend_o[i]` one on the next clock edge. The bit then stays one until it is cleared.
- R3: An acknowledge on `src_clr[i]` makes `pend_o[i]` zero on the next clock edge. If set and acknowledge for the same source arrive in the same cycle, set wins and the bit is one.
- R4: A write to word address 3 updates the mask. For source i, data bit 2i+1 sets mask bit i and data bit 2i clears it. If both bits are one, or both are zero, mask bit i does not change.
- R5: Write data is ANDed with the byte enables before it acts: `bus_be[k]` enables data bits 8k+7..8k. A field in a disabled byte has no effect.
- R6: `irq_o` is one exactly when `pend_o & mask_o` is nonzero. After any register update, including a mask write, the new value shows on `irq_o` in the same cycle that `pend_o` and `mask_o` change.
- R7: While `irq_o` is one, `cause_out` equals `cause_in` with bit 10 forced to one and bits 6:2 forced to zero. While `irq_o` is zero, `cause_out` equals `cause_in`.
- R8: A write to word address 0 with data bit 11 set (byte 1 enabled) clears pending bit 5 on the next clock edge. A set pulse on `src_set[5]` in the same cycle wins.
- R9: Writes to any word address other than 0 and 3 change neither `pend_o` nor `mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 6 | Per-source set pulses |
| src_clr | input | 6 | Per-source acknowledge pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address of the write |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables of the write |
| cause_in | input | 32 | CPU cause word before the merge |
| pend_o | output | 6 | Pending register |
| mask_o | output | 6 | Mask register |
| irq_o | output | 1 | CPU hardware interrupt line |
| cause_out | output | 32 | Cause word with interrupt-pending 2 merged in |

## Verification
Directed steps come first. One source is raised with its mask bit both clear and set, which shows that the mask really gates the line. Mask writes with both pair bits set and with one byte disabled show that a no-op field differs from a real clear. Same-cycle set and acknowledge, both through the acknowledge pulses and through the mode-register acknowledge, show which one wins. A constrained random phase then drives sparse set and acknowledge pulses, writes to all sixteen addresses with random byte enables, and random cause words. Every cycle, the bench compares `pend_o`, `mask_o`, `irq_o` and `cause_out` against bench functions. This exposes any ordering or decode error.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC = 6;

    typedef enum logic [2:0] {
        SRC_SIGPROC = 3'd0,
        SRC_SERIAL  = 3'd1,
        SRC_AUDIO   = 3'd2,
        SRC_VIDEO   = 3'd3,
        SRC_PARPORT = 3'd4,
        SRC_DISPLAY = 3'd5
    } src_id_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (set_i[g])
                pend_q[g] <= 1'b1;
            else if (clr_i[g])
                pend_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [2*N-1:0] pair_i,
    output logic [N-1:0]   mask_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic up_on, up_off;
        assign up_on  = wr_i &  pair_i[2*g+1] & ~pair_i[2*g];
        assign up_off = wr_i & ~pair_i[2*g+1] &  pair_i[2*g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[g] <= 1'b0;
            else if (up_on)
                mask_q[g] <= 1'b1;
            else if (up_off)
                mask_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_cause_merge.sv
module irq_cause_merge #(
    parameter int CW      = 32,
    parameter int IP_BIT  = 10,
    parameter int EXC_LSB = 2,
    parameter int EXC_MSB = 6
) (
    input  logic          irq_i,
    input  logic [CW-1:0] cause_i,
    output logic [CW-1:0] cause_o
);
    localparam logic [CW-1:0] IP_MASK  = CW'(1) << IP_BIT;
    localparam logic [CW-1:0] EXC_MASK =
        ((CW'(1) << (EXC_MSB - EXC_LSB + 1)) - CW'(1)) << EXC_LSB;

    always_comb begin
        if (irq_i)
            cause_o = (cause_i | IP_MASK) & ~EXC_MASK;
        else
            cause_o = cause_i;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int CAUSE_W    = 32,
    parameter int MODE_ADDR  = 0,
    parameter int MASK_ADDR  = 3,
    parameter int DP_ACK_BIT = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [irq_agg_pkg::NUM_SRC-1:0] src_set,
    input  logic [irq_agg_pkg::NUM_SRC-1:0] src_clr,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic [DATA_W/8-1:0]           bus_be,
    input  logic [CAUSE_W-1:0]            cause_in,
    output logic [irq_agg_pkg::NUM_SRC-1:0] pend_o,
    output logic [irq_agg_pkg::NUM_SRC-1:0] mask_o,
    output logic                          irq_o,
    output logic [CAUSE_W-1:0]            cause_out
);
    import irq_agg_pkg::*;

    localparam int BE_W   = DATA_W / 8;
    localparam int PAIR_W = 2 * NUM_SRC;

    logic [DATA_W-1:0] bit_en;
    logic [DATA_W-1:0] eff_data;
    logic              wr_mode, wr_mask;
    src_vec_t          clr_all;

    for (genvar b = 0; b < BE_W; b++) begin : g_be
        assign bit_en[8*b +: 8] = {8{bus_be[b]}};
    end

    assign eff_data = bus_wdata & bit_en;
    assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
    assign wr_mask  = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));

    always_comb begin
        clr_all = src_clr;
        if (wr_mode && eff_data[DP_ACK_BIT])
            clr_all[SRC_DISPLAY] = 1'b1;
    end

    logic unused_data;
    assign unused_data = ^eff_data[DATA_W-1:PAIR_W];

    irq_pending_bank #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (clr_all),
        .pend_q (pend_o)
    );

    irq_mask_bank #(.N(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_mask),
        .pair_i (eff_data[PAIR_W-1:0]),
        .mask_q (mask_o)
    );

    assign irq_o = |(pend_o & mask_o);

    irq_cause_merge #(.CW(CAUSE_W)) u_cause (
        .irq_i   (irq_o),
        .cause_i (cause_in),
        .cause_o (cause_out)
    );
endmodule

// File: rtl/irq_aggregator_checker.sv
module irq_aggregator_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  src_set,
    input logic [5:0]  src_clr,
    input logic        bus_wr,
    input logic [31:0] cause_in,
    input logic [5:0]  pend_o,
    input logic [5:0]  mask_o,
    input logic        irq_o,
    input logic [31:0] cause_out
);
    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != 6'd0) |=> ((pend_o & $past(src_set)) == $past(src_set)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != 6'd0) |=> ((pend_o & $past(src_clr & ~src_set)) == 6'd0));

    assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set == 6'd0 && src_clr == 6'd0 && !bus_wr) |=> $stable(pend_o));

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask_o));

    assert_no_irq_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == 6'd0 || pend_o == 6'd0) |-> !irq_o);

    assert_cause_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cause_out[10] && cause_out[6:2] == 5'd0));

    assert_cause_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (cause_out == cause_in));
endmodule

bind irq_aggregator irq_aggregator_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .bus_wr    (bus_wr),
    .cause_in  (cause_in),
    .pend_o    (pend_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o),
    .cause_out (cause_out)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_set = '0, src_clr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] cause_in = '0;
    logic [5:0]  pend_o, mask_o;
    logic        irq_o;
    logic [31:0] cause_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [5:0] pend_m = '0, mask_m = '0;

    always #2.5 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .cause_in(cause_in), .pend_o(pend_o),
        .mask_o(mask_o), .irq_o(irq_o), .cause_out(cause_out)
    );

    function automatic logic [31:0] eff(input logic [31:0] d, input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
        return d & m;
    endfunction

    function automatic logic [5:0] pend_next(input logic [5:0] p);
        logic [5:0] c;
        logic [31:0] e;
        e = eff(bus_wdata, bus_be);
        c = src_clr;
        if (bus_wr && bus_addr == 4'd0 && e[11]) c[5] = 1'b1;
        return (p & ~c) | src_set;
    endfunction

    function automatic logic [5:0] mask_next(input logic [5:0] m);
        logic [31:0] e;
        logic [5:0] r;
        e = eff(bus_wdata, bus_be);
        r = m;
        if (bus_wr && bus_addr == 4'd3)
            for (int i = 0; i < 6; i++) begin
                if (e[2*i+1] && !e[2*i]) r[i] = 1'b1;
                else if (e[2*i] && !e[2*i+1]) r[i] = 1'b0;
            end
        return r;
    endfunction

    function automatic logic [31:0] cause_exp(input logic irq, input logic [31:0] c);
        return irq ? ((c | 32'h400) & ~32'h7C) : c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic irq_m;
        irq_m = |(pend_m & mask_m);
        check({tag, " pend"}, 32'(pend_o), 32'(pend_m));
        check({tag, " mask"}, 32'(mask_o), 32'(mask_m));
        check({tag, " irq R6"}, 32'(irq_o), 32'(irq_m));
        check({tag, " cause R7"}, cause_out, cause_exp(irq_m, cause_in));
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        pend_m = pend_next(pend_m);
        mask_m = mask_next(mask_m);
        @(negedge clk);
        compare_all(tag);
        src_set = '0; src_clr = '0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pend reset", 32'(pend_o), 32'd0);
        check("R1 mask reset", 32'(mask_o), 32'd0);
        check("R1 irq reset", 32'(irq_o), 32'd0);

        cause_in = 32'hFFFF_FFFF;
        src_set = 6'b000100; tick("R2 audio set, masked off");
        tick("R2 audio sticky");
        wr(4'd3, 32'h0000_0020, 4'h1, "R4 mask set audio");
        tick("R6 irq after mask");
        wr(4'd3, 32'h0000_0030, 4'hF, "R4 both bits no-op");
        wr(4'd3, 32'h0000_0010, 4'h0, "R5 disabled byte ignored");
        wr(4'd7, 32'h0000_0010, 4'hF, "R9 other address ignored");
        wr(4'd3, 32'h0000_0010, 4'h1, "R4 mask clear audio");
        src_set = 6'b000100; src_clr = 6'b000100; tick("R3 set wins over ack");
        src_clr = 6'b000100; tick("R3 ack clears");
        src_set = 6'b100000; tick("R2 display set");
        wr(4'd3, 32'h0000_0800, 4'h2, "R4 mask display via byte1");
        wr(4'd0, 32'h0000_0800, 4'h1, "R5 mode ack byte off");
        src_set = 6'b100000; wr(4'd0, 32'h0000_0800, 4'h2, "R8 set wins over mode ack");
        wr(4'd0, 32'h0000_0800, 4'h2, "R8 mode ack clears display");
        cause_in = 32'h0000_007C;
        src_set = 6'b100000; tick("R7 cause merge exc cleared");

        for (int n = 0; n < 2000; n++) begin
            src_set   = 6'($urandom & $urandom & $urandom);
            src_clr   = 6'($urandom & $urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = ($urandom % 2) ? (($urandom % 2) ? 4'd3 : 4'd0) : 4'($urandom);
            bus_wdata = $urandom;
            bus_be    = 4'($urandom);
            cause_in  = $urandom;
            tick("random R3 R4 R8 R9");
        end
        finish_run();
    end
endmodule